// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects two external interrupt sources for a small microcontroller and presents them to the CPU as two level request lines. The primary source is a dedicated active-low pin. A static configuration input can add a group of port pins to that pin as further active-low inputs. The secondary source is a single separate active-low port pin. Every input passes through a two-flop synchroniser. A falling edge on the synchronised line sets a request latch for that source.

Software reaches the block through one status/control register, with a read strobe and a write strobe. The register holds an enable bit for each source and a read-only view of each request latch. It also holds a write-one acknowledge bit for each source, which clears that latch and always reads 0. Each request output stays high while its latch and its enable are both set. A request that is never acknowledged therefore keeps asking. Pulses that signal STOP or WAIT entry force the primary enable on, so that the external line can always wake the part.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the primary enable reads 1, the secondary enable reads 0, both request flags read 0, both request outputs are 0 and reg_rdata is 0.
- R2: A falling edge on irq_n sets the primary flag. The flag becomes visible on the third rising clock edge after the pin falls (two synchroniser flops, then the latch).
- R3: irq_pri is 1 exactly when the primary flag and the primary enable are both 1.
- R4: A stop_entry or wait_entry pulse sets the primary enable to 1 on the next edge. This holds even if the same cycle writes 0 to the enable bit.
- R5: With cfg_port_irq = 1, a falling edge on any port_n pin sets the primary flag, the same as irq_n does. With cfg_port_irq = 0, port_n activity leaves the flag at 0.
- R6: A falling edge on sec_n sets the secondary flag. irq_sec is 1 exactly when the secondary flag and the secondary enable are both 1. The request stays high for as long as the flag is left uncleared.
- R7: Writing 1 to bit 1 (secondary acknowledge) clears the secondary flag. Writing 1 to bit 5 (primary acknowledge) clears the primary flag. Writing 0 to either bit has no effect, and both bits always read 0.
- R8: Writes to bit 6 (primary flag) and bit 2 (secondary flag) have no effect on either flag.
- R9: If a new edge tries to set a flag in the same cycle as an acknowledge write for that flag, the set wins and the flag stays 1.
- R10: The register layout is fixed. Bit 7 is the primary enable (read/write) and bit 6 the primary flag. Bit 3 is the secondary enable (read/write) and bit 2 the secondary flag. Bits 5 and 1 are the acknowledge bits, and bits 4 and 0 read 0. reg_rdata is loaded on the edge where reg_rd is 1 and holds its value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_port_irq | input | 1 | Static option: port pins join the primary request |
| irq_n | input | 1 | Dedicated primary interrupt pin, active low |
| port_n | input | PORT_W | Port pins optionally ORed onto the primary request, active low |
| sec_n | input | 1 | Secondary interrupt pin, active low |
| stop_entry | input | 1 | Pulse on STOP entry |
| wait_entry | input | 1 | Pulse on WAIT entry |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_pri | output | 1 | Primary interrupt request to the CPU |
| irq_sec | output | 1 | Secondary interrupt request to the CPU |

## Verification
The assertions check the following on every cycle:
- Each request output is gated by its enable.
- STOP and WAIT entry always leave the primary enable on.
- An acknowledge clears a flag unless a set arrives in the same cycle, and a set always wins over an acknowledge.
- An unacknowledged flag is never lost, and the acknowledge bit positions never read 1.

The bench scenarios are needed for the rest:
- the three-edge latency from a pin to its flag;
- the port OR option swept over every port pin in both settings of the option;
- the reset values and the full layout of the register;
- a sweep of every combination of enable and flag for both outputs.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int DATA_W_DEF  = 8;
  localparam int BIT_PEN     = 7;
  localparam int BIT_PFLAG   = 6;
  localparam int BIT_PACK    = 5;
  localparam int BIT_SEN     = 3;
  localparam int BIT_SFLAG   = 2;
  localparam int BIT_SACK    = 1;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '1;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= active;
  end

  assign rise = active & ~prev_q;
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_port_irq,
  input  logic              irq_n,
  input  logic [PORT_W-1:0] port_n,
  input  logic              sec_n,
  input  logic              stop_entry,
  input  logic              wait_entry,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pri,
  output logic              irq_sec
);
  localparam int NPIN = PORT_W + 2;

  logic [NPIN-1:0]   pins_sync;
  logic              s_irq, s_sec;
  logic [PORT_W-1:0] s_port;
  logic              pri_active, sec_active;
  logic              pri_set, sec_set;
  logic              pri_ack, sec_ack;
  logic              pri_flag, sec_flag;
  logic              pen_q, sen_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] status;
  logic              unused_wbits;

  eirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sec_n, port_n, irq_n}),
    .dout (pins_sync)
  );

  assign s_irq  = pins_sync[0];
  assign s_port = pins_sync[PORT_W:1];
  assign s_sec  = pins_sync[NPIN-1];

  assign pri_active = ~s_irq | (cfg_port_irq & ~(&s_port));
  assign sec_active = ~s_sec;

  eirq_edge u_pri_edge (.clk(clk), .rst(rst), .active(pri_active), .rise(pri_set));
  eirq_edge u_sec_edge (.clk(clk), .rst(rst), .active(sec_active), .rise(sec_set));

  assign pri_ack = reg_wr & reg_wdata[BIT_PACK];
  assign sec_ack = reg_wr & reg_wdata[BIT_SACK];

  eirq_flag u_pri_flag (.clk(clk), .rst(rst), .set(pri_set), .clr(pri_ack), .q(pri_flag));
  eirq_flag u_sec_flag (.clk(clk), .rst(rst), .set(sec_set), .clr(sec_ack), .q(sec_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      pen_q <= 1'b1;
      sen_q <= 1'b0;
    end else begin
      if (stop_entry || wait_entry) pen_q <= 1'b1;
      else if (reg_wr)              pen_q <= reg_wdata[BIT_PEN];
      if (reg_wr)                   sen_q <= reg_wdata[BIT_SEN];
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_PEN]   = pen_q;
    status[BIT_PFLAG] = pri_flag;
    status[BIT_SEN]   = sen_q;
    status[BIT_SFLAG] = sec_flag;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= status;
  end

  assign reg_rdata = rdata_q;
  assign irq_pri   = pri_flag & pen_q;
  assign irq_sec   = sec_flag & sen_q;

  assign unused_wbits = ^{reg_wdata[BIT_PFLAG], reg_wdata[BIT_SFLAG], reg_wdata[4], reg_wdata[0]};
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_entry,
  input logic              wait_entry,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_pri,
  input logic              irq_sec,
  input logic              pri_flag,
  input logic              sec_flag,
  input logic              pen_q,
  input logic              sen_q,
  input logic              pri_set,
  input logic              sec_set
);
  p_pri_gate_r3: assert property (@(posedge clk) disable iff (rst) irq_pri |-> (pen_q && pri_flag));
  p_sec_gate_r6: assert property (@(posedge clk) disable iff (rst) irq_sec |-> (sen_q && sec_flag));
  p_wake_en_r4: assert property (@(posedge clk) disable iff (rst) (stop_entry || wait_entry) |=> pen_q);
  p_sec_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[BIT_SACK] && !sec_set) |=> !sec_flag);
  p_pri_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[BIT_PACK] && !pri_set) |=> !pri_flag);
  p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[BIT_PACK] == 1'b0) && (reg_rdata[BIT_SACK] == 1'b0));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst) sec_set |=> sec_flag);
  p_pset_wins_r9: assert property (@(posedge clk) disable iff (rst) pri_set |=> pri_flag);
  p_sec_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_flag && !(reg_wr && reg_wdata[BIT_SACK])) |=> sec_flag);
  p_pri_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pri_flag && !(reg_wr && reg_wdata[BIT_PACK])) |=> pri_flag);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_entry (stop_entry),
  .wait_entry (wait_entry),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq_pri    (irq_pri),
  .irq_sec    (irq_sec),
  .pri_flag   (pri_flag),
  .sec_flag   (sec_flag),
  .pen_q      (pen_q),
  .sen_q      (sen_q),
  .pri_set    (pri_set),
  .sec_set    (sec_set)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int PORT_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_port_irq = 1'b0;
  logic              irq_n = 1'b1;
  logic [PORT_W-1:0] port_n = '1;
  logic              sec_n = 1'b1;
  logic              stop_entry = 1'b0;
  logic              wait_entry = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_pri, irq_sec;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DATA_W-1:0] rv;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .cfg_port_irq(cfg_port_irq), .irq_n(irq_n),
    .port_n(port_n), .sec_n(sec_n), .stop_entry(stop_entry),
    .wait_entry(wait_entry), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pri(irq_pri), .irq_sec(irq_sec)
  );

  function automatic logic [7:0] img(input logic pen, pf, sen, sf);
    return {pen, pf, 1'b0, 1'b0, sen, sf, 1'b0, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pin index: 0 = irq_n, 1..PORT_W = port_n, PORT_W+1 = sec_n
  task automatic drive(input int idx, input logic v);
    if (idx == 0) irq_n = v;
    else if (idx == PORT_W + 1) sec_n = v;
    else port_n[idx-1] = v;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); drive(idx, 1'b0);
    idle(4);
    drive(idx, 1'b1);
    idle(4);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata at reset", reg_rdata, 0);
    check("R1 irq_pri at reset", irq_pri, 0);
    check("R1 irq_sec at reset", irq_sec, 0);
    rd(rv);
    check("R1 R10 register after reset", rv, img(1, 0, 0, 0));

    // R2 latency: visible after third rising edge
    @(negedge clk); irq_n = 1'b0;
    @(negedge clk); check("R2 not yet after 1 edge", irq_pri, 0);
    @(negedge clk); check("R2 not yet after 2 edges", irq_pri, 0);
    @(negedge clk); check("R2 set after 3 edges", irq_pri, 1);
    irq_n = 1'b1; idle(4);
    rd(rv); check("R2 flag in register", rv, img(1, 1, 0, 0));

    // R8 writes to flag positions ignored; R7 write 0 to ack no effect
    wr(8'b1100_0100);
    rd(rv); check("R8 flag write ignored", rv, img(1, 1, 0, 0));
    wr(8'b1000_0000);
    rd(rv); check("R7 ack written 0 keeps flag", rv, img(1, 1, 0, 0));
    wr(8'b1010_0000);
    rd(rv); check("R7 primary ack clears", rv, img(1, 0, 0, 0));

    // R4 stop/wait force enable, even against write of 0
    wr(8'h00);
    rd(rv); check("R4 enable writable to 0", rv, img(0, 0, 0, 0));
    @(negedge clk); stop_entry = 1'b1;
    @(negedge clk); stop_entry = 1'b0;
    rd(rv); check("R4 stop forces enable", rv, img(1, 0, 0, 0));
    @(negedge clk); wait_entry = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); wait_entry = 1'b0; reg_wr = 1'b0;
    rd(rv); check("R4 wait beats write of 0", rv, img(1, 0, 0, 0));

    // R5 port option sweep
    for (int c = 0; c < 2; c++) begin
      cfg_port_irq = c[0];
      for (int p = 1; p <= PORT_W; p++) begin
        pulse(p);
        rd(rv);
        check($sformatf("R5 cfg=%0d port%0d", c, p - 1), rv, img(1, c[0], 0, 0));
        wr(8'b1010_0000);
      end
    end
    cfg_port_irq = 1'b0;

    // R6 secondary edge, persistence
    pulse(PORT_W + 1);
    rd(rv); check("R6 sec flag set", rv, img(1, 0, 0, 1));
    check("R6 irq_sec off with enable 0", irq_sec, 0);
    wr(8'b1000_1000);
    idle(20);
    check("R6 irq_sec persists", irq_sec, 1);
    wr(8'b1000_1100);
    check("R8 sec flag write no clear", irq_sec, 1);
    wr(8'b1000_1010);
    check("R7 sec ack clears request", irq_sec, 0);
    rd(rv); check("R7 R10 ack reads 0", rv, img(1, 0, 1, 0));

    // R3/R6 sweep enables x flags
    for (int f = 0; f < 2; f++) begin
      if (f == 1) begin pulse(0); pulse(PORT_W + 1); end
      for (int e = 0; e < 4; e++) begin
        wr({e[1], 3'b000, e[0], 3'b000});
        check($sformatf("R3 pri f=%0d e=%0d", f, e), irq_pri, e[1] & f[0]);
        check($sformatf("R6 sec f=%0d e=%0d", f, e), irq_sec, e[0] & f[0]);
      end
    end
    wr(8'b1010_1010);
    check("R7 both acked", {irq_pri, irq_sec}, 0);

    // R9 set wins over ack in the same cycle
    @(negedge clk); sec_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'b1000_1010;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    check("R9 sec set beats ack", irq_sec, 1);
    sec_n = 1'b1; idle(4);
    @(negedge clk); irq_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'b1010_1000;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    check("R9 pri set beats ack", irq_pri, 1);
    irq_n = 1'b1; idle(4);
    rd(rv); check("R10 final layout", rv, img(1, 1, 1, 1));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule